// File: doc/BRIEF.md
# Multi-Master SCL Clock Synchronizer

This block produces the serial clock for one bus master that shares an open-drain, wired-AND clock line with other masters. It never drives the line high. It either pulls the line low through `scl_pull` or lets go of it. It reads the true line level back through a synchronizer and times its own low and high phases in system-clock cycles, using two programmable lengths.

A master measures its low phase from the falling edge it observes on the line, whichever master caused that edge. When its own low count ends it releases the line. If another master still holds the line low, the block waits and does not count. It starts timing its high phase only after it sees the line go high. Any falling edge it observes during the high phase ends that phase at once.

The masters all start timing from the same observed edges. As a result the shared clock is low for as long as the slowest low phase and high for as long as the quickest high phase, with the same synchronizer latency added to each. The strobes mark the observed line edges for data logic that works alongside the block.

Top module: `scl_clk_sync`

## Requirements
- R1: During reset `scl_pull`, `wait_hi`, `rise_stb` and `fall_stb` are all 0.
- R2: When `run_en` is sampled low, the next cycle shows `scl_pull`=0 and `wait_hi`=0, and the phase count is cleared. A later enable therefore starts a complete low phase and does not continue a partial one.
- R3: On the first clock edge that samples `run_en` high after it was low, the block begins its low phase, so `scl_pull` is 1 in the following cycle.
- R4: With a single master on the line, the line stays low for L+3 system cycles and high for H+3 cycles. Here L and H are the programmed low and high lengths, and 3 is the latency of the two synchronizer stages plus the edge register.
- R5: A programmed length of 0 behaves exactly like a length of 1.
- R6: With several masters enabled together on one wired-AND line, the line is low for max(L)+3 cycles and high for min(H)+3 cycles, where the max and min are taken over all enabled masters.
- R7: When the block releases the line at the end of its low count, `wait_hi` is 1 in that same cycle. It stays 1 until a rising edge is observed, and no high counting takes place meanwhile.
- R8: `fall_stb` (and likewise `rise_stb`) is a one-cycle pulse. For a line level that is low (high) in cycle c-2 and high (low) in cycle c-3, the pulse appears in cycle c. No pulse appears in any other cycle.
- R9: A falling edge observed during the high phase ends that phase, and `scl_pull` is 1 in the next cycle.
- R10: A rising edge observed while waiting starts the high phase, so in the next cycle `wait_hi` and `scl_pull` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Enables clock generation; when low the line is released and the count is cleared |
| low_period | input | CNT_W | Length of the low phase in system cycles (0 counts as 1) |
| high_period | input | CNT_W | Length of the high phase in system cycles (0 counts as 1) |
| scl_in | input | 1 | Raw level read back from the shared clock line |
| scl_pull | output | 1 | 1 = pull the line low; 0 = release the line |
| rise_stb | output | 1 | One-cycle pulse for each observed rising edge |
| fall_stb | output | 1 | One-cycle pulse for each observed falling edge |
| wait_hi | output | 1 | Line released by this master but still held low elsewhere |

## Verification
The checker takes `run_en` and both period values as quasi-static with respect to the line: the bench changes them only while every master is disabled and the line has settled high. The properties also assume that the line is idle-high during reset, because the synchronizer resets to 1. The bench meets this by modelling the line as the inverted OR of the pull outputs of two block instances, so it is high whenever neither master pulls. It also keeps both masters disabled throughout reset and while the periods are reprogrammed.

// File: rtl/scl_clk_sync_pkg.sv
package scl_clk_sync_pkg;

   // Phase of the local clock generator
   typedef enum logic [1:0] {
      PH_OFF  = 2'd0,   // disabled, line released
      PH_LOW  = 2'd1,   // pulling low, counting low length
      PH_WAIT = 2'd2,   // released, line still low elsewhere
      PH_HIGH = 2'd3    // line seen high, counting high length
   } scl_phase_e;

   // Register after the synchronizer used for edge detection
   localparam int unsigned EDGE_STAGES = 1;

endpackage

// File: rtl/scl_sync_chain.sv
module scl_sync_chain #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("scl_sync_chain: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] ff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= {STAGES{RST_VAL}};
      else        ff <= {ff[STAGES-2:0], d};
   end

   assign q = ff[STAGES-1];

endmodule

// File: rtl/scl_edge_det.sv
module scl_edge_det #(
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise,
   output logic fall
);

   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= RST_VAL;
      else        lvl_q <= lvl;
   end

   assign rise =  lvl & ~lvl_q;
   assign fall = ~lvl &  lvl_q;

endmodule

// File: rtl/scl_phase_cnt.sv
module scl_phase_cnt #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic [CNT_W-1:0] length,
   output logic             done
);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] term;

   // a length of zero is handled as one cycle
   assign term = (length == '0) ? '0 : length - 1'b1;
   assign done = (cnt >= term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (clr)           cnt <= '0;
      else if (inc && !done)  cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/scl_clk_sync.sv
module scl_clk_sync
   import scl_clk_sync_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic [CNT_W-1:0] low_period,
   input  logic [CNT_W-1:0] high_period,
   input  logic             scl_in,
   output logic             scl_pull,
   output logic             rise_stb,
   output logic             fall_stb,
   output logic             wait_hi
);

   localparam int unsigned OBS_LAT = SYNC_STAGES + EDGE_STAGES;

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("scl_clk_sync: CNT_W must be at least 2");
      end
      if (OBS_LAT > 8) begin : g_bad_lat
         $error("scl_clk_sync: synchronizer latency unreasonably large");
      end
   endgenerate

   logic             scl_s;
   logic             rise_w, fall_w;
   logic             cnt_clr, cnt_inc, cnt_done;
   logic [CNT_W-1:0] cnt_len;
   scl_phase_e       phase_q, phase_d;

   scl_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (scl_in),
      .q     (scl_s)
   );

   scl_edge_det #(.RST_VAL(1'b1)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (scl_s),
      .rise  (rise_w),
      .fall  (fall_w)
   );

   assign cnt_len = (phase_q == PH_HIGH) ? high_period : low_period;

   scl_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (cnt_clr),
      .inc    (cnt_inc),
      .length (cnt_len),
      .done   (cnt_done)
   );

   // Phase sequencing: low count is anchored to the observed falling edge,
   // high count starts only after the line is observed high.
   always_comb begin
      phase_d = phase_q;
      cnt_clr = 1'b0;
      cnt_inc = 1'b0;
      if (!run_en) begin
         phase_d = PH_OFF;
         cnt_clr = 1'b1;
      end else begin
         unique case (phase_q)
            PH_OFF: begin
               phase_d = PH_LOW;
               cnt_clr = 1'b1;
            end
            PH_LOW: begin
               if (fall_w) begin
                  cnt_clr = 1'b1;
               end else if (cnt_done && !scl_s) begin
                  phase_d = PH_WAIT;
                  cnt_clr = 1'b1;
               end else begin
                  cnt_inc = 1'b1;
               end
            end
            PH_WAIT: begin
               if (rise_w) begin
                  phase_d = PH_HIGH;
                  cnt_clr = 1'b1;
               end
            end
            PH_HIGH: begin
               if (fall_w || cnt_done) begin
                  phase_d = PH_LOW;
                  cnt_clr = 1'b1;
               end else begin
                  cnt_inc = 1'b1;
               end
            end
            default: begin
               phase_d = PH_OFF;
               cnt_clr = 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_OFF;
      else        phase_q <= phase_d;
   end

   assign scl_pull = (phase_q == PH_LOW);
   assign wait_hi  = (phase_q == PH_WAIT);
   assign rise_stb = rise_w;
   assign fall_stb = fall_w;

endmodule

// File: rtl/scl_clk_sync_chk.sv
module scl_clk_sync_chk (
   input logic clk,
   input logic rst_n,
   input logic run_en,
   input logic scl_pull,
   input logic wait_hi,
   input logic rise_stb,
   input logic fall_stb
);

   p_release_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (!scl_pull && !wait_hi));

   p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_en) |=> scl_pull);

   p_wait_on_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(scl_pull) && $past(run_en)) |-> wait_hi);

   p_wait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_hi && run_en && !rise_stb) |=> wait_hi);

   p_fall_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fall_stb |=> !fall_stb);

   p_rise_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rise_stb |=> !rise_stb);

   p_fall_pulls_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && fall_stb && !scl_pull && !wait_hi) |=> scl_pull);

   p_rise_ends_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_hi && run_en && rise_stb) |=> (!wait_hi && !scl_pull));

endmodule

bind scl_clk_sync scl_clk_sync_chk i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run_en   (run_en),
   .scl_pull (scl_pull),
   .wait_hi  (wait_hi),
   .rise_stb (rise_stb),
   .fall_stb (fall_stb)
);

// File: tb/test_scl_clk_sync.sv
module test_scl_clk_sync;

   localparam int W        = 16;
   localparam int HALF_CLK = 2500;   // 1 ps units: 5 ns period, 200 MHz
   localparam int DRV_DLY  = 100;
   localparam int LAT      = 3;      // two sync stages plus edge register

   typedef struct {
      bit    lvl;
      int    len;
      string tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ra = 1'b0, rb = 1'b0;
   logic [W-1:0] la_p = '0, ha_p = '0, lb_p = '0, hb_p = '0;
   logic pa, pb, line;
   logic rsa, fsa, wa, rsb, fsb, wb;

   int n_chk = 0, n_err = 0;
   bit finished = 0;
   bit armed = 0, run_ok = 0, cur = 1;
   int run_len = 0;
   logic [3:0] hist = 4'hF;
   logic pa_q = 1'b0;
   bit exp_f, exp_r;
   exp_t it;
   exp_t exp_q[$];

   always #HALF_CLK clk = ~clk;

   assign line = ~(pa | pb);

   scl_clk_sync #(.CNT_W(W)) i_scl_clk_sync (
      .clk(clk), .rst_n(rst_n), .run_en(ra), .low_period(la_p), .high_period(ha_p),
      .scl_in(line), .scl_pull(pa), .rise_stb(rsa), .fall_stb(fsa), .wait_hi(wa)
   );

   scl_clk_sync #(.CNT_W(W)) i_scl_clk_sync_peer (
      .clk(clk), .rst_n(rst_n), .run_en(rb), .low_period(lb_p), .high_period(hb_p),
      .scl_in(line), .scl_pull(pb), .rise_stb(rsb), .fall_stb(fsb), .wait_hi(wb)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   // Monitor: strobe timing, wait flag on release, and run lengths popped from the scoreboard
   always @(negedge clk) begin
      if (!rst_n) begin
         hist = 4'hF; cur = 1; run_len = 0; run_ok = 0; pa_q = 1'b0;
      end else begin
         hist  = {hist[2:0], line};
         exp_f = hist[3] & ~hist[2];
         exp_r = ~hist[3] & hist[2];
         if (exp_f || fsa) chk(fsa == exp_f, "R8 fall strobe", int'(fsa), int'(exp_f));
         if (exp_r || rsa) chk(rsa == exp_r, "R8 rise strobe", int'(rsa), int'(exp_r));
         if (pa_q && !pa && ra) chk(wa == 1'b1, "R7 wait flag at release", int'(wa), 1);
         pa_q = pa;
         if (!armed) run_ok = 0;
         if (line != cur) begin
            if (run_ok && armed && exp_q.size() > 0) begin
               it = exp_q.pop_front();
               chk(it.lvl == cur && it.len == run_len, it.tag, run_len, it.len);
            end
            cur = line; run_len = 1; run_ok = armed;
         end else begin
            run_len++;
         end
      end
   end

   // Driver: programs periods, pushes expected low/high lengths, enables masters
   task automatic run_case(input int la, input int ha, input int lb, input int hb,
                           input bit ea, input bit eb, input int nper, input string tag);
      int lo, hi;
      lo = 0; hi = 1 << 30;
      if (ea) begin
         lo = (la == 0) ? 1 : la;
         hi = (ha == 0) ? 1 : ha;
      end
      if (eb) begin
         if (((lb == 0) ? 1 : lb) > lo) lo = (lb == 0) ? 1 : lb;
         if (((hb == 0) ? 1 : hb) < hi) hi = (hb == 0) ? 1 : hb;
      end
      @(negedge clk); #DRV_DLY;
      la_p = W'(la); ha_p = W'(ha); lb_p = W'(lb); hb_p = W'(hb);
      repeat (8) @(negedge clk);
      for (int i = 0; i < nper; i++) begin
         exp_q.push_back('{1'b0, lo + LAT, tag});
         exp_q.push_back('{1'b1, hi + LAT, tag});
      end
      #DRV_DLY;
      armed = 1; ra = ea; rb = eb;
      @(negedge clk);
      if (ea) chk(pa == 1'b1, "R3 low phase after enable", int'(pa), 1);
      if (eb) chk(pb == 1'b1, "R3 low phase after enable (peer)", int'(pb), 1);
      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk); #DRV_DLY;
      armed = 0; ra = 0; rb = 0;
      @(negedge clk);
      chk(pa == 1'b0 && pb == 1'b0, "R2 line released on disable", int'(pa | pb), 0);
      chk(wa == 1'b0, "R2 wait cleared on disable", int'(wa), 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk(pa == 1'b0, "R1 pull in reset", int'(pa), 0);
      chk(wa == 1'b0, "R1 wait in reset", int'(wa), 0);
      chk(rsa == 1'b0, "R1 rise strobe in reset", int'(rsa), 0);
      chk(fsa == 1'b0, "R1 fall strobe in reset", int'(fsa), 0);
      #DRV_DLY rst_n = 1'b1;
      repeat (4) @(negedge clk);
      run_case(5, 7, 0, 0, 1, 0, 3, "R4 single master");
      // re-enable after a mid-phase disable starts a full low phase (R2)
      run_case(0, 0, 0, 0, 1, 0, 3, "R5 R2 zero lengths");
      run_case(4, 10, 9, 6, 1, 1, 3, "R6 R9 R10 two masters, peer longer low");
      run_case(12, 3, 2, 20, 1, 1, 3, "R6 R9 R10 two masters, local longer low");
      run_case(0, 2, 1, 0, 0, 1, 2, "R5 peer only");
      run_case(6, 6, 6, 6, 1, 1, 2, "R6 equal lengths");
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule